// File: doc/BRIEF.md
# Folded Shared-Memory Complex Matrix-Vector Multiplier

The block computes y = W·x for a square complex matrix W of dimension N and a complex vector x. It is meant for applying a precomputed channel-estimation weight matrix to least-squares pilot estimates. Rather than one processing element per output row, a small array of P elements is reused over N/P iterations. Iteration k has element p compute row k·P + p by doing N complex multiply-accumulates, one column per clock cycle. This way the total run time fills the clock budget of a symbol instead of finishing early and sitting idle. In the intended setting, N is 192 (one row per used subcarrier) and P is 16, which gives 12 iterations. The default parameters are a smaller configuration of the same structure.

Matrix rows are spread over P shared memory banks. Row r sits in bank ((r mod P) + ⌊r/P⌋) mod P, so that the bank feeding a given element changes from one iteration to the next. The input vector sits in one further bank that is broadcast to every element. An address generation unit steps through the iteration and column counters. It issues one read address to every bank and produces the first-column, last-column and last-iteration controls. A multiplexer at each element's matrix input picks bank (p + k) mod P in iteration k. After each iteration, the P row results are rounded, saturated and streamed out in row order. A one-cycle done pulse follows the last row.

Top module: `folded_mvm`

## Requirements
- R1: While rst_n is low, and after it rises until start is accepted, y_valid and done are both 0.
- R2: Each result word is sum over c of W[r][c]·x[c] in complex arithmetic. The sum is exact, then scaled by 2^-FRAC with rounding half toward plus infinity. Every data word, on input or output, is packed with the two's-complement real part in the upper DW bits and the imaginary part in the lower DW bits.
- R3: A run emits exactly N result words with y_valid high, in ascending row order from row 0 to row N-1. Each iteration emits its P rows in consecutive cycles.
- R4: done is high for exactly one cycle, the cycle right after the last result word of a run, and never together with y_valid.
- R5: When start is sampled at clock edge 0, done is high between edges (N/P)·N+P+3 and (N/P)·N+P+4.
- R6: A start pulse sampled while a run is in progress has no effect: that run's results, word count and done timing are unchanged.
- R7: A rounded real or imaginary result above 2^(DW-1)-1 is output as 2^(DW-1)-1, and one below -2^(DW-1) is output as -2^(DW-1).
- R8: Writing w_wdata with w_we high stores it as W[w_row][w_col], and writing x_wdata with x_we high stores it as x[x_idx]. The stored contents persist across runs, so a second start without reloading gives the same results.
- R9: Elaboration stops with an error unless P ≥ 2, N is a multiple of P, N ≥ P and 1 ≤ FRAC < DW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; ignored while a run is in progress |
| w_we | input | 1 | Matrix element write enable |
| w_row | input | clog2(N) | Matrix row index of the write |
| w_col | input | clog2(N) | Matrix column index of the write |
| w_wdata | input | 2·DW | Matrix element, real part in upper half |
| x_we | input | 1 | Vector element write enable |
| x_idx | input | clog2(N) | Vector element index of the write |
| x_wdata | input | 2·DW | Vector element, real part in upper half |
| y_valid | output | 1 | Result word valid |
| y_data | output | 2·DW | Result word, real part in upper half |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
The assertions check the framing of a run on every cycle:
- done is a single-cycle pulse.
- done directly follows a result beat.
- Exactly N beats come between done pulses.
- Results appear only while a run is active.
- A start that arrives mid-run leaves the run active until its done.

The correctness of the arithmetic can only be shown by the bench's scenarios. These cover the rotated bank mapping, rounding at the half-LSB point, saturation in both directions, the exact latency and reuse of loaded contents. The bench compares each result word against a value it computes itself.

// File: rtl/fmvm_pkg.sv
package fmvm_pkg;
   // bank that holds a row for a given element slot and iteration
   function automatic int unsigned rot_bank(input int unsigned slot,
                                            input int unsigned iter,
                                            input int unsigned nb);
      return (slot + iter) % nb;
   endfunction
endpackage

// File: rtl/fmvm_agu.sv
module fmvm_agu #(
   parameter int N  = 32,
   parameter int NI = 8,
   localparam int RW = $clog2(N),
   localparam int IW = (NI > 1) ? $clog2(NI) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   output logic          en,
   output logic [IW-1:0] iter,
   output logic [RW-1:0] col,
   output logic          first,
   output logic          last,
   output logic          last_it
);
   logic run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run  <= 1'b0;
         iter <= '0;
         col  <= '0;
      end else if (go) begin
         run  <= 1'b1;
         iter <= '0;
         col  <= '0;
      end else if (run) begin
         if (col == RW'(N - 1)) begin
            col <= '0;
            if (iter == IW'(NI - 1)) run <= 1'b0;
            else                     iter <= iter + 1'b1;
         end else begin
            col <= col + 1'b1;
         end
      end
   end

   assign en      = run;
   assign first   = (col == '0);
   assign last    = (col == RW'(N - 1));
   assign last_it = (iter == IW'(NI - 1));
endmodule

// File: rtl/fmvm_bank.sv
module fmvm_bank #(
   parameter int DEPTH = 256,
   parameter int WID   = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic           clk,
   input  logic           we,
   input  logic [AW-1:0]  waddr,
   input  logic [WID-1:0] wdata,
   input  logic [AW-1:0]  raddr,
   output logic [WID-1:0] rdata
);
   logic [WID-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/fmvm_pe.sv
module fmvm_pe #(
   parameter int DW = 16,
   parameter int AW = 38
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 first,
   input  logic [2*DW-1:0]      w,
   input  logic [2*DW-1:0]      x,
   output logic signed [AW-1:0] acc_re,
   output logic signed [AW-1:0] acc_im
);
   logic signed [DW-1:0]   wr, wi, xr, xi;
   logic signed [2*DW-1:0] p_rr, p_ii, p_ri, p_ir;
   logic signed [AW-1:0]   t_re, t_im;

   always_comb begin
      wr   = signed'(w[2*DW-1:DW]);
      wi   = signed'(w[DW-1:0]);
      xr   = signed'(x[2*DW-1:DW]);
      xi   = signed'(x[DW-1:0]);
      p_rr = wr * xr;
      p_ii = wi * xi;
      p_ri = wr * xi;
      p_ir = wi * xr;
      t_re = AW'(p_rr) - AW'(p_ii);
      t_im = AW'(p_ri) + AW'(p_ir);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_re <= '0;
         acc_im <= '0;
      end else if (en) begin
         acc_re <= first ? t_re : acc_re + t_re;
         acc_im <= first ? t_im : acc_im + t_im;
      end
   end
endmodule

// File: rtl/folded_mvm.sv
module folded_mvm #(
   parameter int N    = 32,
   parameter int P    = 4,
   parameter int DW   = 16,
   parameter int FRAC = 15,
   localparam int RW  = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            w_we,
   input  logic [RW-1:0]   w_row,
   input  logic [RW-1:0]   w_col,
   input  logic [2*DW-1:0] w_wdata,
   input  logic            x_we,
   input  logic [RW-1:0]   x_idx,
   input  logic [2*DW-1:0] x_wdata,
   output logic            y_valid,
   output logic [2*DW-1:0] y_data,
   output logic            done
);
   import fmvm_pkg::*;

   localparam int NI    = N / P;
   localparam int IW    = (NI > 1) ? $clog2(NI) : 1;
   localparam int BW    = $clog2(P);
   localparam int DEPTH = NI * N;
   localparam int BAW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int AW    = 2 * DW + 1 + RW;
   localparam logic signed [AW:0] SMAX = {{(AW-DW+2){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [AW:0] SMIN = {{(AW-DW+2){1'b1}}, {(DW-1){1'b0}}};
   localparam logic signed [AW:0] RND  = {{(AW+1-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

   // R9 elaboration checks
   if (P < 2)                 begin : g_bad_p    $fatal(1, "P must be at least 2");            end
   if (N % P != 0)            begin : g_bad_div  $fatal(1, "N must be a multiple of P");       end
   if (N < P)                 begin : g_bad_n    $fatal(1, "N must not be smaller than P");    end
   if (FRAC < 1 || FRAC >= DW) begin : g_bad_frac $fatal(1, "FRAC must lie in 1..DW-1");       end

   function automatic logic [DW-1:0] rnd_sat(input logic signed [AW-1:0] a);
      logic signed [AW:0] t;
      t = {a[AW-1], a} + RND;
      t = t >>> FRAC;
      if (t > SMAX)      return SMAX[DW-1:0];
      else if (t < SMIN) return SMIN[DW-1:0];
      else               return t[DW-1:0];
   endfunction

   // control and address generation
   logic          busy, go;
   logic          a_en, a_first, a_last, a_last_it;
   logic [IW-1:0] a_it;
   logic [RW-1:0] a_col;

   assign go = start && !busy;

   fmvm_agu #(.N(N), .NI(NI)) u_agu (
      .clk(clk), .rst_n(rst_n), .go(go), .en(a_en), .iter(a_it), .col(a_col),
      .first(a_first), .last(a_last), .last_it(a_last_it)
   );

   // write decode: row r lands in bank ((r mod P) + r/P) mod P
   logic [BW-1:0]  wb_sel;
   logic [BAW-1:0] wb_addr, rd_addr;
   always_comb begin
      int unsigned wit, wp;
      wit     = int'(w_row) / P;
      wp      = int'(w_row) % P;
      wb_sel  = BW'(rot_bank(wp, wit, P));
      wb_addr = BAW'(wit * N + int'(w_col));
      rd_addr = BAW'(int'(a_it) * N + int'(a_col));
   end

   logic [2*DW-1:0] bank_q [P];
   logic [2*DW-1:0] x_q;

   for (genvar b = 0; b < P; b++) begin : g_bank
      fmvm_bank #(.DEPTH(DEPTH), .WID(2*DW)) u_bank (
         .clk(clk), .we(w_we && (wb_sel == BW'(b))), .waddr(wb_addr), .wdata(w_wdata),
         .raddr(rd_addr), .rdata(bank_q[b])
      );
   end

   fmvm_bank #(.DEPTH(N), .WID(2*DW)) u_xbank (
      .clk(clk), .we(x_we), .waddr(x_idx), .wdata(x_wdata),
      .raddr(a_col), .rdata(x_q)
   );

   // stage 1: control aligned with memory read data
   logic          s1_en, s1_first, s1_last, s1_last_it;
   logic [IW-1:0] s1_it;
   logic          s2_cap, s2_last_it;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_en <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0; s1_last_it <= 1'b0;
         s1_it <= '0;   s2_cap <= 1'b0;   s2_last_it <= 1'b0;
      end else begin
         s1_en      <= a_en;
         s1_first   <= a_first;
         s1_last    <= a_last;
         s1_last_it <= a_last_it;
         s1_it      <= a_it;
         s2_cap     <= s1_en && s1_last;
         s2_last_it <= s1_last_it;
      end
   end

   // processing elements with per-iteration bank select
   logic signed [AW-1:0] acc_re [P];
   logic signed [AW-1:0] acc_im [P];

   for (genvar p = 0; p < P; p++) begin : g_pe
      logic [BW-1:0]   sel;
      logic [2*DW-1:0] wsel;
      always_comb begin
         sel  = BW'(rot_bank(p, int'(s1_it), P));
         wsel = bank_q[sel];
      end
      fmvm_pe #(.DW(DW), .AW(AW)) u_pe (
         .clk(clk), .rst_n(rst_n), .en(s1_en), .first(s1_first),
         .w(wsel), .x(x_q), .acc_re(acc_re[p]), .acc_im(acc_im[p])
      );
   end

   // capture, drain in row order, done
   logic [2*DW-1:0] rres [P];
   logic            drn, dfinal, y_last;
   logic [BW-1:0]   didx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drn <= 1'b0; dfinal <= 1'b0; didx <= '0;
         y_valid <= 1'b0; y_data <= '0; y_last <= 1'b0; done <= 1'b0; busy <= 1'b0;
      end else begin
         done <= y_last;
         if (go)          busy <= 1'b1;
         else if (y_last) busy <= 1'b0;
         if (drn) begin
            y_valid <= 1'b1;
            y_data  <= rres[didx];
            y_last  <= dfinal && (didx == BW'(P - 1));
            didx    <= didx + 1'b1;
            if (didx == BW'(P - 1)) drn <= 1'b0;
         end else begin
            y_valid <= 1'b0;
            y_last  <= 1'b0;
         end
         if (s2_cap) begin
            for (int p = 0; p < P; p++) rres[p] <= {rnd_sat(acc_re[p]), rnd_sat(acc_im[p])};
            drn    <= 1'b1;
            didx   <= '0;
            dfinal <= s2_last_it;
         end
      end
   end
endmodule

// File: rtl/fmvm_chk.sv
module fmvm_chk #(
   parameter int N = 32
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic y_valid,
   input logic done
);
   localparam int CW = $clog2(N + 1);
   logic [CW-1:0] vcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)       vcnt <= '0;
      else if (done)    vcnt <= '0;
      else if (y_valid) vcnt <= vcnt + 1'b1;
   end

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R4
   done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(y_valid) && !y_valid);
   // R3
   beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (vcnt == CW'(N)));
   // R3
   beat_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n) y_valid |-> busy);
   // R6
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (busy || done));
endmodule

bind folded_mvm fmvm_chk #(.N(N)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .y_valid(y_valid), .done(done)
);

// File: tb/folded_mvm_test.sv
`timescale 1ns/1ps
module folded_mvm_test;
   localparam int N    = 8;
   localparam int P    = 4;
   localparam int DW   = 16;
   localparam int FRAC = 15;
   localparam int RW   = $clog2(N);
   localparam int LAT  = (N / P) * N + P + 4; // negedges after the start edge until done seen (R5)

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic w_we = 1'b0, x_we = 1'b0;
   logic [RW-1:0] w_row = '0, w_col = '0, x_idx = '0;
   logic [2*DW-1:0] w_wdata = '0, x_wdata = '0;
   logic y_valid, done;
   logic [2*DW-1:0] y_data;

   int nvec = 0, nerr = 0;
   int wre [N][N];
   int wim [N][N];
   int xre [N];
   int xim [N];
   logic [2*DW-1:0] expv [N];
   int unsigned seed = 32'h1234_5678;

   always #2 clk = ~clk;

   folded_mvm #(.N(N), .P(P), .DW(DW), .FRAC(FRAC)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .w_we(w_we), .w_row(w_row), .w_col(w_col),
      .w_wdata(w_wdata), .x_we(x_we), .x_idx(x_idx), .x_wdata(x_wdata),
      .y_valid(y_valid), .y_data(y_data), .done(done)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] sat(input longint a);
      longint t;
      t = (a + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
      if (t > 32767)  t = 32767;
      if (t < -32768) t = -32768;
      return DW'(t);
   endfunction

   task automatic build_expect();
      for (int r = 0; r < N; r++) begin
         longint ar = 0, ai = 0;
         for (int c = 0; c < N; c++) begin
            ar += longint'(wre[r][c]) * xre[c] - longint'(wim[r][c]) * xim[c];
            ai += longint'(wre[r][c]) * xim[c] + longint'(wim[r][c]) * xre[c];
         end
         expv[r] = {sat(ar), sat(ai)};
      end
   endtask

   function automatic int rnd_val();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 16) % 24001) - 12000;
   endfunction

   task automatic load_all();
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            @(negedge clk);
            w_we = 1'b1; w_row = RW'(r); w_col = RW'(c);
            w_wdata = {DW'(wre[r][c]), DW'(wim[r][c])};
         end
      @(negedge clk); w_we = 1'b0;
      for (int c = 0; c < N; c++) begin
         @(negedge clk);
         x_we = 1'b1; x_idx = RW'(c); x_wdata = {DW'(xre[c]), DW'(xim[c])};
      end
      @(negedge clk); x_we = 1'b0;
   endtask

   task automatic run_check(input string req, input bit inject);
      int cnt = 0, beats = 0;
      bit seen = 1'b0, prev_v = 1'b0;
      build_expect();
      @(negedge clk); start = 1'b1;
      while (!seen && cnt < 2000) begin
         @(negedge clk);
         cnt++;
         start = inject && (cnt == 5 || cnt == 12);
         if (y_valid) begin
            if (beats < N)
               chk(y_data == expv[beats], $sformatf("%s row %0d", req, beats), y_data, expv[beats]);
            else
               chk(1'b0, "R3 extra beat", beats, N);
            beats++;
         end
         if (done) begin
            seen = 1'b1;
            chk(prev_v && !y_valid, "R4 done follows last beat", prev_v, 1);
            chk(cnt == LAT, "R5 done latency", cnt, LAT);
            chk(beats == N, "R3 beat count", beats, N);
         end
         prev_v = y_valid;
      end
      if (!seen) chk(1'b0, "R5 watchdog, no done", cnt, LAT);
      @(negedge clk);
      chk(!done && !y_valid, "R4 done single cycle", {done, y_valid}, 0);
   endtask

   initial begin
      #400000;
      chk(1'b0, "global watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!y_valid && !done, "R1 in reset", {y_valid, done}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!y_valid && !done, "R1 after reset", {y_valid, done}, 0);

      // R2 R8: pseudo-random contents, exercises the rotated bank select
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin wre[r][c] = rnd_val(); wim[r][c] = rnd_val(); end
      for (int c = 0; c < N; c++) begin xre[c] = rnd_val(); xim[c] = rnd_val(); end
      load_all();
      run_check("R2 random", 1'b0);
      // R8: rerun without reloading
      run_check("R8 rerun", 1'b0);
      // R6: start pulses during the run
      run_check("R6 start mid-run", 1'b1);

      // R2 rounding half up at exactly +/- half LSB
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin wre[r][c] = 0; wim[r][c] = 0; end
      for (int c = 0; c < N; c++) begin xre[c] = 0; xim[c] = 0; end
      xre[0] = 16384; xim[1] = 16384;
      wre[0][0] = 1; wre[1][0] = -1; wim[2][0] = 1; wim[3][1] = 1;
      wre[4][1] = -1; wre[5][0] = 3; wre[6][1] = 2; wim[7][0] = -3;
      load_all();
      run_check("R2 rounding", 1'b0);

      // R7 saturation in both directions
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            wre[r][c] = (r % 2 == 0) ? 32767 : -32768;
            wim[r][c] = (r % 3 == 0) ? -32768 : 32767;
         end
      for (int c = 0; c < N; c++) begin xre[c] = 32767; xim[c] = (c % 2) ? 100 : -100; end
      load_all();
      run_check("R7 saturation", 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule